// File: doc/BRIEF.md
# Local-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Each branch keeps a short private record of its own recent outcomes. That record selects a 2-bit saturating counter in a pattern table, and the pattern table is shared by every branch. The front end presents a branch PC with a static "easy" hint and gets a taken/not-taken answer in the same cycle. The back end returns each resolved branch with its PC, its real outcome and its target, and the predictor trains on it.

Branches that the compiler marks as easy are kept out of the two-level structure completely. They are predicted taken without a table read, and their resolutions do not train the history or the counters. A small four-entry target store is filled only by explicit writes from software. When it hits on a taken prediction, the redirect target comes out in the same cycle, so there is no bubble. When it misses, a larger direct-mapped backup target store, filled by taken resolutions, gives the target one cycle later.

Top module: `bp_local_top`

## Requirements
- R1: After reset every history is 0000, every counter holds 01 (weakly not taken) and both target stores are empty. Outputs are low in any cycle without a prediction request.
- R2: Each branch's 4-bit history sits in a 64-entry table indexed by PC[9:4]. An unhinted resolution shifts the outcome (1 = taken) into bit 0 and drops bit 3.
- R3: Four pattern tables of 16 counters each are selected by PC[5:4] and indexed by the history. An unhinted prediction is taken when the counter is 2 or 3. Training counts up on taken and down on not taken, and holds at 3 and at 0.
- R4: A hinted prediction is always taken. A hinted resolution changes neither a history nor a counter.
- R5: When a resolution and a prediction arrive in the same cycle, the prediction sees the state as if the resolution had already been applied. This holds for both the history and the counter.
- R6: The four-entry fast target store is written only by the explicit write port and matches on the full PC. A write to a PC already held replaces its target in place. A write to a new PC fills the slot named by a round-robin pointer (starting at slot 0), and only then does the pointer advance.
- R7: A prediction that is taken and hits the fast store raises the fast redirect with the stored target in the same cycle. A not-taken prediction raises no redirect.
- R8: Every taken resolution, hinted or not, writes its target into a 16-entry backup store. The store is indexed by PC[7:4] and tagged with the full PC. A taken prediction that misses the fast store but hits the backup store raises the slow redirect one cycle later, carrying the backup target.
- R9: Lookups in either target store see the contents from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_valid | input | 1 | Prediction request |
| pred_pc | input | PC_W | PC of branch to predict |
| pred_hint | input | 1 | Branch marked statically easy |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| fast_redirect | output | 1 | Zero-bubble redirect from fast store |
| fast_target | output | PC_W | Target for fast redirect |
| slow_redirect | output | 1 | Redirect from backup store, one cycle after request |
| slow_target | output | PC_W | Target for slow redirect |
| res_valid | input | 1 | Resolution update |
| res_pc | input | PC_W | PC of resolved branch |
| res_taken | input | 1 | Actual outcome |
| res_target | input | PC_W | Actual target |
| res_hint | input | 1 | Resolved branch was hinted easy |
| ftb_wr | input | 1 | Explicit fast-store write |
| ftb_wr_pc | input | PC_W | PC to install |
| ftb_wr_target | input | PC_W | Target to install |

## Verification
Several properties are checked every cycle. A hinted request always yields taken. Outputs stay quiet when there is no request. At most one fast-store entry ever matches a PC. The round-robin pointer advances only on writes of new PCs. A slow redirect always follows a taken request that missed the fast store. The learning behaviour can only be shown by the bench's scenarios, with a scoreboard model: history shifting, counter saturation, the same-cycle forwarding, hint filtering, eviction order and aliasing in the backup store.

// File: rtl/bp_pkg.sv
// Shared sizes and helpers for the local-history branch predictor.
// Assumes power-of-two table sizes.
package bp_pkg;
    parameter int PC_W       = 32;
    parameter int HIST_W     = 4;
    parameter int HIST_IDX_W = 6;
    parameter int IDX_LSB    = 4;
    parameter int SEL_W      = 2;
    parameter int FTB_N      = 4;
    parameter int BK_IDX_W   = 4;

    typedef logic [1:0] ctr_t;

    // Saturating 2-bit counter step.
    function automatic ctr_t ctr_step(input ctr_t c, input logic up);
        if (up)  return (c == 2'd3) ? c : c + 2'd1;
        else     return (c == 2'd0) ? c : c - 2'd1;
    endfunction
endpackage

// File: rtl/bp_hist_table.sv
// Per-branch outcome history table. One write port from resolution,
// one read port for prediction. The read returns the post-write value
// when both ports address the same entry in the same cycle.
module bp_hist_table #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 4,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken,
    output logic [HIST_W-1:0] wr_old_hist
);
    logic [HIST_W-1:0] hist_q [DEPTH];
    logic [HIST_W-1:0] wr_new_hist;

    // Old and shifted history of the entry being trained.
    always_comb begin
        wr_old_hist = hist_q[wr_idx];
        wr_new_hist = {wr_old_hist[HIST_W-2:0], wr_taken};
    end

    // Read with forwarding of the same-cycle write.
    always_comb begin
        rd_hist = (wr_en && (wr_idx == rd_idx)) ? wr_new_hist : hist_q[rd_idx];
    end

    // Storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else if (wr_en) begin
            hist_q[wr_idx] <= wr_new_hist;
        end
    end
endmodule

// File: rtl/bp_pht.sv
// Shared pattern table of 2-bit saturating counters, indexed by
// {table select, history}. The read forwards a same-cycle update.
module bp_pht #(
    parameter int IDX_W  = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output bp_pkg::ctr_t       rd_ctr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_taken
);
    bp_pkg::ctr_t ctr_q [DEPTH];
    bp_pkg::ctr_t ctr_new;

    // Next value of the counter being trained.
    always_comb ctr_new = bp_pkg::ctr_step(ctr_q[wr_idx], wr_taken);

    // Read with forwarding.
    always_comb begin
        rd_ctr = (wr_en && (wr_idx == rd_idx)) ? ctr_new : ctr_q[rd_idx];
    end

    // Counter storage; reset to weakly not taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= 2'b01;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_new;
        end
    end
endmodule

// File: rtl/bp_fast_tbuf.sv
// Small fully associative target store loaded only by explicit writes.
// Full-PC match; in-place update on a repeat PC, round-robin fill otherwise.
// Lookup sees contents before a same-cycle write. N must be a power of two.
module bp_fast_tbuf #(
    parameter int PC_W = 32,
    parameter int N    = 4,
    localparam int PW  = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic [N-1:0]    hit_vec,
    output logic [PC_W-1:0] lk_tgt,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_tgt,
    output logic            wr_miss,
    output logic [PW-1:0]   ptr
);
    logic [N-1:0]    vld_q;
    logic [PC_W-1:0] pc_q  [N];
    logic [PC_W-1:0] tgt_q [N];
    logic [PW-1:0]   ptr_q;
    logic [N-1:0]    wr_match;
    logic [PW-1:0]   wr_slot;

    // Per-entry comparators for lookup and write.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g]  = vld_q[g] && (pc_q[g] == lk_pc);
        assign wr_match[g] = vld_q[g] && (pc_q[g] == wr_pc);
    end

    assign wr_miss = ~|wr_match;
    assign ptr     = ptr_q;

    // Target select from the matching entry.
    always_comb begin
        lk_tgt = '0;
        for (int i = 0; i < N; i++) if (hit_vec[i]) lk_tgt = lk_tgt | tgt_q[i];
    end

    // Destination slot: matching entry, else the round-robin slot.
    always_comb begin
        wr_slot = ptr_q;
        for (int i = 0; i < N; i++) if (wr_match[i]) wr_slot = PW'(i);
    end

    // Entry and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
            for (int i = 0; i < N; i++) begin
                pc_q[i]  <= '0;
                tgt_q[i] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_slot] <= 1'b1;
            pc_q[wr_slot]  <= wr_pc;
            tgt_q[wr_slot] <= wr_tgt;
            if (wr_miss) ptr_q <= ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/bp_backup_tbuf.sv
// Direct-mapped backup target store with full-PC tags. Written by taken
// resolutions; lookup result is registered (one cycle later) and uses
// the contents from before a same-cycle write.
module bp_backup_tbuf #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int LSB   = 4,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_req,
    input  logic [PC_W-1:0] lk_pc,
    output logic            hit_q,
    output logic [PC_W-1:0] tgt_q,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_tgt
);
    logic [DEPTH-1:0] vld;
    logic [PC_W-1:0]  tag  [DEPTH];
    logic [PC_W-1:0]  dest [DEPTH];
    logic [IDX_W-1:0] lk_idx, wr_idx;

    assign lk_idx = lk_pc[LSB +: IDX_W];
    assign wr_idx = wr_pc[LSB +: IDX_W];

    // Storage and registered lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld   <= '0;
            hit_q <= 1'b0;
            tgt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag[i]  <= '0;
                dest[i] <= '0;
            end
        end else begin
            hit_q <= lk_req && vld[lk_idx] && (tag[lk_idx] == lk_pc);
            tgt_q <= dest[lk_idx];
            if (wr_en) begin
                vld[wr_idx]  <= 1'b1;
                tag[wr_idx]  <= wr_pc;
                dest[wr_idx] <= wr_tgt;
            end
        end
    end
endmodule

// File: rtl/bp_local_top.sv
// Two-level local branch direction predictor with hint filtering, a
// software-loaded fast target store and a backup target store.
// Assumes one prediction and one resolution at most per cycle.
module bp_local_top #(
    parameter int PC_W       = bp_pkg::PC_W,
    parameter int HIST_W     = bp_pkg::HIST_W,
    parameter int HIST_IDX_W = bp_pkg::HIST_IDX_W,
    parameter int IDX_LSB    = bp_pkg::IDX_LSB,
    parameter int SEL_W      = bp_pkg::SEL_W,
    parameter int FTB_N      = bp_pkg::FTB_N,
    parameter int BK_IDX_W   = bp_pkg::BK_IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pred_valid,
    input  logic [PC_W-1:0] pred_pc,
    input  logic            pred_hint,
    output logic            pred_taken,
    output logic            fast_redirect,
    output logic [PC_W-1:0] fast_target,
    output logic            slow_redirect,
    output logic [PC_W-1:0] slow_target,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [PC_W-1:0] res_target,
    input  logic            res_hint,
    input  logic            ftb_wr,
    input  logic [PC_W-1:0] ftb_wr_pc,
    input  logic [PC_W-1:0] ftb_wr_target
);
    localparam int PHT_IDX_W = SEL_W + HIST_W;
    localparam int PTR_W     = $clog2(FTB_N);

    logic                  train_en;
    logic [HIST_W-1:0]     pred_hist, res_old_hist;
    bp_pkg::ctr_t          pred_ctr;
    logic [PHT_IDX_W-1:0]  pred_pht_idx, res_pht_idx;
    logic [FTB_N-1:0]      fast_hit_vec;
    logic                  fast_hit;
    logic                  ftb_wr_miss;
    logic [PTR_W-1:0]      ftb_ptr;
    logic                  bk_req;

    // Only unhinted resolutions train the two-level structure.
    assign train_en = res_valid && !res_hint;

    bp_hist_table #(.IDX_W(HIST_IDX_W), .HIST_W(HIST_W)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (pred_pc[IDX_LSB +: HIST_IDX_W]),
        .rd_hist    (pred_hist),
        .wr_en      (train_en),
        .wr_idx     (res_pc[IDX_LSB +: HIST_IDX_W]),
        .wr_taken   (res_taken),
        .wr_old_hist(res_old_hist)
    );

    // Pattern table index: table select from PC, entry from history.
    assign pred_pht_idx = {pred_pc[IDX_LSB +: SEL_W], pred_hist};
    assign res_pht_idx  = {res_pc[IDX_LSB +: SEL_W], res_old_hist};

    bp_pht #(.IDX_W(PHT_IDX_W)) u_pht (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (pred_pht_idx),
        .rd_ctr  (pred_ctr),
        .wr_en   (train_en),
        .wr_idx  (res_pht_idx),
        .wr_taken(res_taken)
    );

    bp_fast_tbuf #(.PC_W(PC_W), .N(FTB_N)) u_ftb (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_pc  (pred_pc),
        .hit_vec(fast_hit_vec),
        .lk_tgt (fast_target),
        .wr_en  (ftb_wr),
        .wr_pc  (ftb_wr_pc),
        .wr_tgt (ftb_wr_target),
        .wr_miss(ftb_wr_miss),
        .ptr    (ftb_ptr)
    );

    // Direction and fast redirect decision.
    always_comb begin
        pred_taken    = pred_valid && (pred_hint || pred_ctr[1]);
        fast_hit      = |fast_hit_vec;
        fast_redirect = pred_taken && fast_hit;
        bk_req        = pred_taken && !fast_hit;
    end

    bp_backup_tbuf #(.PC_W(PC_W), .IDX_W(BK_IDX_W), .LSB(IDX_LSB)) u_bk (
        .clk   (clk),
        .rst_n (rst_n),
        .lk_req(bk_req),
        .lk_pc (pred_pc),
        .hit_q (slow_redirect),
        .tgt_q (slow_target),
        .wr_en (res_valid && res_taken),
        .wr_pc (res_pc),
        .wr_tgt(res_target)
    );
endmodule

// File: rtl/bp_local_chk.sv
// Property checker for bp_local_top, attached by bind.
module bp_local_chk #(
    parameter int N     = 4,
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pred_valid,
    input logic             pred_hint,
    input logic             pred_taken,
    input logic             fast_redirect,
    input logic             slow_redirect,
    input logic             fast_hit,
    input logic [N-1:0]     fast_hit_vec,
    input logic             ftb_wr,
    input logic             ftb_wr_miss,
    input logic [PTR_W-1:0] ftb_ptr
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> (!pred_taken && !fast_redirect));

    p_hint_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_hint) |-> pred_taken);

    p_fast_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fast_hit_vec));

    p_rr_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ftb_wr && ftb_wr_miss) |=> (ftb_ptr == PTR_W'($past(ftb_ptr) + 1'b1)));

    p_rr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ftb_wr && !ftb_wr_miss) |=> $stable(ftb_ptr));

    p_slow_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slow_redirect |-> $past(pred_valid && pred_taken && !fast_hit));
endmodule

bind bp_local_top bp_local_chk #(.N(FTB_N), .PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pred_valid   (pred_valid),
    .pred_hint    (pred_hint),
    .pred_taken   (pred_taken),
    .fast_redirect(fast_redirect),
    .slow_redirect(slow_redirect),
    .fast_hit     (fast_hit),
    .fast_hit_vec (fast_hit_vec),
    .ftb_wr       (ftb_wr),
    .ftb_wr_miss  (ftb_wr_miss),
    .ftb_ptr      (ftb_ptr)
);

// File: tb/bp_local_top_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver computes expected outputs from a requirement
// model and queues them; a monitor compares after outputs settle.
module bp_local_top_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pred_valid = 0, pred_hint = 0, res_valid = 0, res_taken = 0, res_hint = 0, ftb_wr = 0;
    logic [W-1:0] pred_pc = 0, res_pc = 0, res_target = 0, ftb_wr_pc = 0, ftb_wr_target = 0;
    logic         pred_taken, fast_redirect, slow_redirect;
    logic [W-1:0] fast_target, slow_target;

    always #2.5 clk = ~clk;

    bp_local_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_hint(pred_hint),
        .pred_taken(pred_taken), .fast_redirect(fast_redirect), .fast_target(fast_target),
        .slow_redirect(slow_redirect), .slow_target(slow_target),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_hint(res_hint),
        .ftb_wr(ftb_wr), .ftb_wr_pc(ftb_wr_pc), .ftb_wr_target(ftb_wr_target)
    );

    typedef struct {
        logic         tk, fr, sr;
        logic [W-1:0] ft, st;
        string        req;
    } exp_t;

    exp_t   sb_q[$];
    event   drv_ev;
    int     checks = 0, fails = 0;
    bit     done = 0;

    // Reference model state.
    logic [3:0]   m_hist [64];
    logic [1:0]   m_ctr  [64];
    logic         m_fv [4];
    logic [W-1:0] m_fpc [4], m_ftg [4];
    int           m_rr;
    logic         m_bv [16];
    logic [W-1:0] m_bpc [16], m_btg [16];
    logic         pend_sr;
    logic [W-1:0] pend_st;

    task automatic model_reset();
        for (int i = 0; i < 64; i++) begin m_hist[i] = 0; m_ctr[i] = 2'd1; end
        for (int i = 0; i < 4; i++)  begin m_fv[i] = 0; m_fpc[i] = 0; m_ftg[i] = 0; end
        for (int i = 0; i < 16; i++) begin m_bv[i] = 0; m_bpc[i] = 0; m_btg[i] = 0; end
        m_rr = 0; pend_sr = 0; pend_st = 0;
    endtask

    // One cycle of stimulus plus expected-result generation.
    task automatic cyc(input logic pv, input logic [W-1:0] ppc, input logic ph,
                       input logic rv, input logic [W-1:0] rpc, input logic rt,
                       input logic [W-1:0] rtg, input logic rh,
                       input logic wv, input logic [W-1:0] wpc, input logic [W-1:0] wtg,
                       input string req);
        exp_t e;
        logic       trn, fh;
        int         hi, ci, phi, pci, bi, fi;
        logic [3:0] nh, ph_hist;
        logic [1:0] nc, pc_ctr;
        @(negedge clk);
        pred_valid = pv; pred_pc = ppc; pred_hint = ph;
        res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtg; res_hint = rh;
        ftb_wr = wv; ftb_wr_pc = wpc; ftb_wr_target = wtg;
        e.req = req;
        e.sr = pend_sr; e.st = pend_st;
        trn = rv && !rh;
        hi = int'(rpc[9:4]);
        nh = {m_hist[hi][2:0], rt};
        ci = int'({rpc[5:4], m_hist[hi]});
        nc = m_ctr[ci];
        if (rt && nc != 3) nc = nc + 1; else if (!rt && nc != 0) nc = nc - 1;
        phi = int'(ppc[9:4]);
        ph_hist = (trn && hi == phi) ? nh : m_hist[phi];
        pci = int'({ppc[5:4], ph_hist});
        pc_ctr = (trn && ci == pci) ? nc : m_ctr[pci];
        e.tk = pv && (ph || pc_ctr >= 2);
        fh = 0; e.ft = 0;
        for (int i = 0; i < 4; i++) if (m_fv[i] && m_fpc[i] == ppc) begin fh = 1; e.ft = m_ftg[i]; end
        e.fr = e.tk && fh;
        bi = int'(ppc[7:4]);
        pend_sr = e.tk && !fh && m_bv[bi] && m_bpc[bi] == ppc;
        pend_st = m_btg[bi];
        if (trn) begin m_hist[hi] = nh; m_ctr[ci] = nc; end
        if (rv && rt) begin
            bi = int'(rpc[7:4]);
            m_bv[bi] = 1; m_bpc[bi] = rpc; m_btg[bi] = rtg;
        end
        if (wv) begin
            fi = -1;
            for (int i = 0; i < 4; i++) if (m_fv[i] && m_fpc[i] == wpc) fi = i;
            if (fi < 0) begin fi = m_rr; m_rr = (m_rr + 1) % 4; end
            m_fv[fi] = 1; m_fpc[fi] = wpc; m_ftg[fi] = wtg;
        end
        sb_q.push_back(e);
        ->drv_ev;
    endtask

    task automatic predict(input logic [W-1:0] pc, input logic h, input string req);
        cyc(1, pc, h, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask
    task automatic resolve(input logic [W-1:0] pc, input logic t, input logic [W-1:0] tg,
                           input logic h, input string req);
        cyc(0, 0, 0, 1, pc, t, tg, h, 0, 0, 0, req);
    endtask
    task automatic ftb_write(input logic [W-1:0] pc, input logic [W-1:0] tg, input string req);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, pc, tg, req);
    endtask

    task automatic cmp(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compare settled outputs against the queued expectation.
    initial begin
        forever begin
            exp_t e;
            @(drv_ev);
            #1;
            e = sb_q.pop_front();
            cmp(e.req, "pred_taken", W'(pred_taken), W'(e.tk));
            cmp(e.req, "fast_redirect", W'(fast_redirect), W'(e.fr));
            if (e.fr) cmp(e.req, "fast_target", fast_target, e.ft);
            cmp(e.req, "slow_redirect", W'(slow_redirect), W'(e.sr));
            if (e.sr) cmp(e.req, "slow_target", slow_target, e.st);
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state, idle and first prediction.
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
        predict(32'h0000_1230, 0, "R1");
        predict(32'h0000_5000, 0, "R1");

        // R2/R3: loop pattern TTTN on branch A, alternating on branch B.
        for (int it = 0; it < 32; it++) begin
            predict(32'h0000_1230, 0, "R2");
            resolve(32'h0000_1230, (it % 4) != 3, 32'h0000_0800, 0, "R2");
            predict(32'h0000_1240, 0, "R3");
            resolve(32'h0000_1240, it[0], 32'h0000_0900, 0, "R3");
        end
        // R3: saturation with a long taken run, then one not-taken.
        for (int it = 0; it < 10; it++) begin
            predict(32'h0000_4440, 0, "R3");
            resolve(32'h0000_4440, 1, 32'h0000_0a00, 0, "R3");
        end
        resolve(32'h0000_4440, 0, 0, 0, "R3");
        predict(32'h0000_4440, 0, "R3");
        for (int it = 0; it < 6; it++) resolve(32'h0000_4450, 0, 0, 0, "R3");
        predict(32'h0000_4450, 0, "R3");

        // R4: hinted resolutions leave a fresh branch untrained.
        for (int it = 0; it < 4; it++) resolve(32'h0000_3370, 1, 32'h0000_0b00, 1, "R4");
        predict(32'h0000_3370, 0, "R4");
        predict(32'h0000_3370, 1, "R4");

        // R5: resolution and prediction on the same PC in one cycle.
        for (int it = 0; it < 8; it++)
            cyc(1, 32'h0000_2000, 0, 1, 32'h0000_2000, 1, 32'h0000_0c00, 0, 0, 0, 0, "R5");
        cyc(1, 32'h0000_2000, 0, 1, 32'h0000_2000, 0, 0, 0, 0, 0, 0, "R5");

        // R6/R7: fill fast store past capacity; first entry evicted.
        for (int it = 0; it < 5; it++)
            ftb_write(32'h0000_7000 + 32'(it * 16), 32'h0001_0000 + 32'(it), "R6");
        predict(32'h0000_7000, 1, "R6");
        predict(32'h0000_7010, 1, "R7");
        predict(32'h0000_7040, 1, "R7");
        ftb_write(32'h0000_7010, 32'h0002_2222, "R6");
        predict(32'h0000_7010, 1, "R6");
        ftb_write(32'h0000_7050, 32'h0003_3333, "R6");
        predict(32'h0000_7020, 1, "R6");
        predict(32'h0000_7030, 1, "R6");
        predict(32'h0000_7030, 0, "R7");

        // R9: write and lookup of the same PC in one cycle sees old contents.
        cyc(1, 32'h0000_7060, 1, 0, 0, 0, 0, 0, 1, 32'h0000_7060, 32'h0004_4444, "R9");
        predict(32'h0000_7060, 1, "R9");

        // R8: backup store, tag aliasing and next-cycle redirect.
        resolve(32'h0000_6000, 1, 32'h0000_abc0, 1, "R8");
        predict(32'h0000_6000, 1, "R8");
        predict(32'h0000_6100, 1, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
        predict(32'h0000_6000, 0, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");

        @(negedge clk);
        #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule